// File: doc/BRIEF.md
# Priority Address Window Decoder

This block decides which target interface owns each address on a 36-bit local bus. It keeps a bank of twelve programmable windows. Each window is a naturally aligned power-of-two region, from 4 KB up to 32 GB, and carries a target ID. A request address is compared against every enabled window at the same time. The block returns a hit flag, a miss flag, the chosen target ID and the index of the window that matched.

Software programs the windows through a simple register port. All registers sit inside a 1 MB configuration region. The location of that region is held in a base register at offset zero of the region itself. Reading that register therefore returns the region's own location, and rewriting it moves every register, the window registers included, to the new place.

Top module: `addr_window_decoder`

## Requirements
- R1: There are twelve windows. Window i has its base register at region offset 0x100 + 16*i and its attribute register at offset 0x104 + 16*i. The base register keeps address bits [35:12] in data bits [23:0]. The attribute register keeps the enable in bit 31, the target ID in bits [24:20] and the size code in bits [5:0]. A read returns the stored fields and zero in every other bit.
- R2: A size code n gives a window of 2^(n+1) bytes. Only codes 0x0B (4 KB) through 0x22 (32 GB) are legal. A window with any other code never matches.
- R3: An enabled window matches a request when the request's address bits from the window size up to bit 35 equal the same bits of the window base. Base bits below the window size are ignored, so every window is aligned to its own size.
- R4: When several enabled windows match, the window with the lowest index supplies the target ID and the window index.
- R5: When no window matches, dec_hit is 0, dec_miss is 1, and dec_target and dec_win are both 0. When a window matches, dec_hit is 1 and dec_miss is 0.
- R6: After reset, every window register reads zero and every window is disabled. The configuration base register reads 0x000FF700, which places the region at 0x0_FF70_0000.
- R7: The configuration base register is at region offset 0x0 and keeps address bits [35:12]. The region spans 1 MB and is selected by address bits [35:20]. Writing this register moves the region. After the move, accesses outside the new region read zero, and writes outside it change nothing.
- R8: The decode is combinational from req_addr to the dec_* outputs. A register write takes effect at the next rising clock edge.
- R9: A window whose enable bit is 0 never matches, whatever its size and base.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 36 | Register access address (read or write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| req_addr | input | 36 | Address to be decoded |
| dec_hit | output | 1 | A window matched |
| dec_miss | output | 1 | No window matched |
| dec_target | output | 5 | Target ID of the winning window, 0 on a miss |
| dec_win | output | 4 | Index of the winning window, 0 on a miss |

## Verification
The decode outputs and the read data are combinational. They are valid in the same cycle as req_addr and reg_addr, so the bench changes those inputs just after a falling edge and samples 1 ns later, with no clock edge in between. A write takes effect only at the rising edge that captures it. The write-timing scenario therefore sets up a write and samples the decode once before that edge, expecting the old result, and once 1 ns after it, expecting the new one. All other checks run only after the write task has passed the capturing edge.

// File: rtl/awd_pkg.sv
// Package: awd_pkg
// Shared constants, the per-window configuration record and the size
// helpers used by the address window decoder.
// Assumes: a 36-bit local address space with a 4 KB page granule.
package awd_pkg;

    localparam int ADDR_W   = 36;
    localparam int PG_LSB   = 12;
    localparam int PG_W     = ADDR_W - PG_LSB;
    localparam int SIZE_W   = 6;
    localparam int SIZE_MIN = 11;
    localparam int SIZE_MAX = 34;
    localparam int TGT_W    = 5;
    localparam int DATA_W   = 32;
    localparam int RGN_LSB  = 20;

    // Attribute register field positions
    localparam int ATTR_EN_BIT  = 31;
    localparam int ATTR_TGT_LSB = 20;

    typedef struct packed {
        logic                en;
        logic [TGT_W-1:0]    tgt;
        logic [SIZE_W-1:0]   size;
        logic [PG_W-1:0]     base;
    } win_cfg_t;

    // True when the size code lies in the legal range
    function automatic logic size_legal(input logic [SIZE_W-1:0] code);
        return (int'(code) >= SIZE_MIN) && (int'(code) <= SIZE_MAX);
    endfunction

    // Page-number bits that take part in the compare for a given size code
    function automatic logic [PG_W-1:0] page_mask(input logic [SIZE_W-1:0] code);
        logic [PG_W-1:0] m;
        for (int j = 0; j < PG_W; j++) begin
            m[j] = ((j + PG_LSB) >= (int'(code) + 1));
        end
        return m;
    endfunction

endpackage

// File: rtl/awd_regfile.sv
// Module: awd_regfile
// Holds the relocatable configuration base and the window base/attribute
// registers, and serves combinational reads. Writes land at the rising edge.
// Assumes: NUM_WIN <= 16 so that one 4-bit slot field indexes the windows.
module awd_regfile
    import awd_pkg::*;
#(
    parameter int            NUM_WIN = 12,
    parameter logic [PG_W-1:0] CFG_RST = 24'h0FF700
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output win_cfg_t          win_cfg [NUM_WIN]
);

    localparam int              OFF_W      = RGN_LSB;
    localparam logic [OFF_W-1:0] WIN_BLK   = 20'h00100;
    localparam int              STRIDE_LSB = 4;
    localparam int              SLOT_W     = 4;

    logic [PG_W-1:0]   cfg_q;
    logic              in_rgn;
    logic [OFF_W-1:0]  off;
    logic              sel_cfg;
    logic              in_blk;
    logic [SLOT_W-1:0] slot;
    logic [3:0]        kind;
    logic [NUM_WIN-1:0] sel_base;
    logic [NUM_WIN-1:0] sel_attr;

    // Region select and offset split
    always_comb begin
        in_rgn  = (reg_addr[ADDR_W-1:RGN_LSB] == cfg_q[PG_W-1:RGN_LSB-PG_LSB]);
        off     = reg_addr[OFF_W-1:0];
        sel_cfg = in_rgn && (off == '0);
        in_blk  = in_rgn && (off[OFF_W-1:8] == WIN_BLK[OFF_W-1:8]);
        slot    = off[STRIDE_LSB +: SLOT_W];
        kind    = off[3:0];
    end

    // Configuration base register, reset to its default location
    always_ff @(posedge clk) begin
        if (!rst_n)                 cfg_q <= CFG_RST;
        else if (reg_wr && sel_cfg) cfg_q <= reg_wdata[PG_W-1:0];
    end

    assert_cfg_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_cfg) |=> (cfg_q == $past(reg_wdata[PG_W-1:0])));

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic              en_q;
        logic [TGT_W-1:0]  tgt_q;
        logic [SIZE_W-1:0] size_q;
        logic [PG_W-1:0]   base_q;

        // Per-window register selects
        always_comb begin
            sel_base[i] = in_blk && (slot == SLOT_W'(i)) && (kind == 4'h0);
            sel_attr[i] = in_blk && (slot == SLOT_W'(i)) && (kind == 4'h4);
        end

        // Window base register
        always_ff @(posedge clk) begin
            if (!rst_n)                     base_q <= '0;
            else if (reg_wr && sel_base[i]) base_q <= reg_wdata[PG_W-1:0];
        end

        // Window attribute register
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q   <= 1'b0;
                tgt_q  <= '0;
                size_q <= '0;
            end else if (reg_wr && sel_attr[i]) begin
                en_q   <= reg_wdata[ATTR_EN_BIT];
                tgt_q  <= reg_wdata[ATTR_TGT_LSB +: TGT_W];
                size_q <= reg_wdata[SIZE_W-1:0];
            end
        end

        assert_attr_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && sel_attr[i]) |=> (win_cfg[i].en == $past(reg_wdata[ATTR_EN_BIT])));

        assign win_cfg[i] = '{en: en_q, tgt: tgt_q, size: size_q, base: base_q};
    end

    // Read multiplexer; unselected or unused bits read zero
    always_comb begin
        reg_rdata = '0;
        if (sel_cfg) reg_rdata[PG_W-1:0] = cfg_q;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (sel_base[i]) reg_rdata[PG_W-1:0] = win_cfg[i].base;
            if (sel_attr[i]) begin
                reg_rdata[ATTR_EN_BIT]              = win_cfg[i].en;
                reg_rdata[ATTR_TGT_LSB +: TGT_W]    = win_cfg[i].tgt;
                reg_rdata[SIZE_W-1:0]               = win_cfg[i].size;
            end
        end
    end

endmodule

// File: rtl/awd_win_match.sv
// Module: awd_win_match
// Compares one request address against every window in parallel and
// returns one match bit per window.
// Assumes: the base is a page number; bits below the window size are don't-care.
module awd_win_match
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 12
) (
    input  logic [ADDR_W-1:0]  req_addr,
    input  win_cfg_t           win_cfg [NUM_WIN],
    output logic [NUM_WIN-1:0] match
);

    logic [PG_W-1:0] req_pg;
    assign req_pg = req_addr[ADDR_W-1:PG_LSB];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        logic [PG_W-1:0] mask;
        logic            live;

        // Masked page compare gated by enable and a legal size
        always_comb begin
            mask     = page_mask(win_cfg[i].size);
            live     = win_cfg[i].en && size_legal(win_cfg[i].size);
            match[i] = live && (((req_pg ^ win_cfg[i].base) & mask) == '0);
        end
    end

endmodule

// File: rtl/awd_prio_pick.sv
// Module: awd_prio_pick
// Picks the lowest-numbered matching window and returns its index, target
// and a one-hot grant; all outputs are zero when nothing matches.
// Assumes: match bit i belongs to window i.
module awd_prio_pick
    import awd_pkg::*;
#(
    parameter int NUM_WIN = 12,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic [NUM_WIN-1:0] match,
    input  win_cfg_t           win_cfg [NUM_WIN],
    output logic               hit,
    output logic [IDX_W-1:0]   idx,
    output logic [TGT_W-1:0]   tgt,
    output logic [NUM_WIN-1:0] grant
);

    // Scan from the top down so the lowest match is written last
    always_comb begin
        hit   = 1'b0;
        idx   = '0;
        tgt   = '0;
        grant = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                idx      = IDX_W'(i);
                tgt      = win_cfg[i].tgt;
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/addr_window_decoder.sv
// Module: addr_window_decoder
// Top of the priority address window decoder. It ties together the register
// bank, the parallel window compare and the lowest-index priority pick.
// Assumes: synchronous active-low reset; decode is combinational.
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int              NUM_WIN = 12,
    parameter logic [PG_W-1:0] CFG_RST = 24'h0FF700,
    localparam int             IDX_W   = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [35:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [35:0]       req_addr,
    output logic              dec_hit,
    output logic              dec_miss,
    output logic [4:0]        dec_target,
    output logic [IDX_W-1:0]  dec_win
);

    win_cfg_t           win_cfg [NUM_WIN];
    logic [NUM_WIN-1:0] match;
    logic [NUM_WIN-1:0] grant;

    awd_regfile #(.NUM_WIN(NUM_WIN), .CFG_RST(CFG_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .win_cfg   (win_cfg)
    );

    awd_win_match #(.NUM_WIN(NUM_WIN)) u_match (
        .req_addr (req_addr),
        .win_cfg  (win_cfg),
        .match    (match)
    );

    awd_prio_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .match   (match),
        .win_cfg (win_cfg),
        .hit     (dec_hit),
        .idx     (dec_win),
        .tgt     (dec_target),
        .grant   (grant)
    );

    // Miss flag is the complement of the hit
    assign dec_miss = !dec_hit;

    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_lowest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> ((match & ((NUM_WIN'(1) << dec_win) - NUM_WIN'(1))) == '0));

    assert_hit_has_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> match[dec_win]);

    assert_miss_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (match == '0) |-> (!dec_hit && dec_miss && dec_target == '0 && dec_win == '0));

endmodule

// File: tb/addr_window_decoder_bench.sv
`timescale 1ns/1ps
module addr_window_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [35:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [35:0] req_addr = '0;
    logic        dec_hit;
    logic        dec_miss;
    logic [4:0]  dec_target;
    logic [3:0]  dec_win;

    int n_chk = 0;
    int n_bad = 0;
    logic [23:0] cur_base = 24'h0FF700;

    always #2.5 clk = ~clk;

    addr_window_decoder u_addr_window_decoder (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
        .dec_hit(dec_hit), .dec_miss(dec_miss), .dec_target(dec_target),
        .dec_win(dec_win)
    );

    function automatic logic [31:0] attr(input logic en, input logic [4:0] t,
                                         input logic [5:0] sz);
        return {en, 6'b0, t, 14'b0, sz};
    endfunction

    function automatic logic [35:0] ra(input logic [23:0] b, input logic [19:0] off);
        return {b[23:8], off};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [35:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [35:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic dec_chk(input string tag, input logic [35:0] a, input logic hit,
                           input logic [4:0] t, input logic [3:0] w);
        @(negedge clk);
        req_addr = a;
        #1;
        check(tag, {dec_hit, dec_miss, 3'b0, dec_target, dec_win},
                   {hit, !hit, 3'b0, t, w});
    endtask

    task automatic t_reset;
        rd_chk("R6 cfg base reset", ra(cur_base, 20'h0), 32'h000FF700);
        rd_chk("R6 win0 attr reset", ra(cur_base, 20'h104), 32'h0);
        rd_chk("R6 win11 base reset", ra(cur_base, 20'h1B0), 32'h0);
        dec_chk("R5 miss after reset", 36'h0_8000_0000, 1'b0, 5'd0, 4'd0);
    endtask

    task automatic t_basic;
        wr(ra(cur_base, 20'h130), 32'h0008_0000);
        wr(ra(cur_base, 20'h134), attr(1'b1, 5'd7, 6'h1B));
        rd_chk("R1 win3 base readback", ra(cur_base, 20'h130), 32'h0008_0000);
        rd_chk("R1 win3 attr readback", ra(cur_base, 20'h134), 32'h8070_001B);
        wr(ra(cur_base, 20'h1B4), 32'h7FFF_FFFF);
        rd_chk("R1 win11 unused bits zero", ra(cur_base, 20'h1B4), 32'h01F0_003F);
        dec_chk("R3 low edge of 256MB", 36'h0_8000_0000, 1'b1, 5'd7, 4'd3);
        dec_chk("R3 high edge of 256MB", 36'h0_8FFF_FFFF, 1'b1, 5'd7, 4'd3);
        dec_chk("R5 just above window", 36'h0_9000_0000, 1'b0, 5'd0, 4'd0);
        dec_chk("R5 just below window", 36'h0_7FFF_FFFF, 1'b0, 5'd0, 4'd0);
    endtask

    task automatic t_overlap;
        wr(ra(cur_base, 20'h110), 32'h0008_0000);
        wr(ra(cur_base, 20'h114), attr(1'b1, 5'd2, 6'h0B));
        dec_chk("R4 lower window wins", 36'h0_8000_0010, 1'b1, 5'd2, 4'd1);
        dec_chk("R2 4KB upper byte", 36'h0_8000_0FFF, 1'b1, 5'd2, 4'd1);
        dec_chk("R2 past 4KB falls to win3", 36'h0_8000_1000, 1'b1, 5'd7, 4'd3);
    endtask

    task automatic t_sizes;
        wr(ra(cur_base, 20'h100), 32'h0);
        wr(ra(cur_base, 20'h104), attr(1'b1, 5'd9, 6'h0A));
        dec_chk("R2 code 0x0A illegal", 36'h0_0000_0000, 1'b0, 5'd0, 4'd0);
        wr(ra(cur_base, 20'h104), attr(1'b1, 5'd9, 6'h23));
        dec_chk("R2 code 0x23 illegal", 36'h0_0000_0000, 1'b0, 5'd0, 4'd0);
        wr(ra(cur_base, 20'h104), attr(1'b1, 5'd9, 6'h22));
        dec_chk("R2 32GB covers low half", 36'h7_FFFF_FFFF, 1'b1, 5'd9, 4'd0);
        dec_chk("R4 win0 over win1 and win3", 36'h0_8000_0000, 1'b1, 5'd9, 4'd0);
        dec_chk("R2 32GB upper half misses", 36'hF_0000_0000, 1'b0, 5'd0, 4'd0);
        wr(ra(cur_base, 20'h104), attr(1'b0, 5'd9, 6'h22));
        dec_chk("R9 disabled window ignored", 36'h0_8000_0000, 1'b1, 5'd2, 4'd1);
    endtask

    task automatic t_align;
        wr(ra(cur_base, 20'h150), 32'h0012_3456);
        wr(ra(cur_base, 20'h154), attr(1'b1, 5'd11, 6'h13));
        rd_chk("R1 base keeps low bits", ra(cur_base, 20'h150), 32'h0012_3456);
        dec_chk("R3 aligned start", 36'h1_2340_0000, 1'b1, 5'd11, 4'd5);
        dec_chk("R3 aligned end", 36'h1_234F_FFFF, 1'b1, 5'd11, 4'd5);
        dec_chk("R3 next MB misses", 36'h1_2350_0000, 1'b0, 5'd0, 4'd0);
    endtask

    task automatic t_relocate;
        wr(ra(cur_base, 20'h0), 32'h000A_0000);
        rd_chk("R7 old location reads zero", 36'h0_FF70_0000, 32'h0);
        cur_base = 24'h0A0000;
        rd_chk("R7 base reads itself", ra(cur_base, 20'h0), 32'h000A_0000);
        rd_chk("R7 windows moved along", ra(cur_base, 20'h134), 32'h8070_001B);
        wr(36'h0_FF70_0134, 32'h0);
        rd_chk("R7 stray write ignored", ra(cur_base, 20'h134), 32'h8070_001B);
        dec_chk("R7 decode unchanged", 36'h0_8800_0000, 1'b1, 5'd7, 4'd3);
    endtask

    task automatic t_timing;
        wr(ra(cur_base, 20'h170), 32'h0020_0000);
        @(negedge clk);
        req_addr  = 36'h2_0000_0000;
        reg_wr    = 1'b1;
        reg_addr  = ra(cur_base, 20'h174);
        reg_wdata = attr(1'b1, 5'd4, 6'h0B);
        #1;
        check("R8 before edge still miss", {dec_hit, dec_target}, {1'b0, 5'd0});
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
        check("R8 after edge hit", {dec_hit, dec_target, dec_win}, {1'b1, 5'd4, 4'd7});
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_overlap();
        t_sizes();
        t_align();
        t_relocate();
        t_timing();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule